// File: doc/BRIEF.md
# Serial-Priority Interrupt Acknowledge Chain

This block models a group of peripheral interrupt nodes that share a single active-low request line. The line behaves as a wired OR. Each node raises a pending flag when its local service request arrives. It holds the shared line low until its own service-clear input removes that flag. The request is level-sensitive: a one-cycle request pulse keeps the line low for as long as the flag stays set.

A small processor stub sits on the other side. It sees the line low and spends a configurable number of preparation cycles. It then raises a one-cycle acknowledge strobe. The strobe enters node 0, which has the highest priority, and is passed on node by node toward the last node.

When the strobe reaches a node, that node acts on the pending state it had when the strobe began:
- If it was pending, it claims the acknowledge. It drives its identification vector onto the shared bus and stops the strobe.
- If it was not pending, it passes the strobe to the next node.

The stub latches the bus value as the vector of the routine to run. If no node claims the strobe, the bus reads all-ones and the stub flags a spurious interrupt. When several nodes request together, repeated acknowledge rounds serve them in chain order.

Top module: `daisy_irq_chain`

## Requirements
- R1: After reset, `irq_n_o` is high, `ack_o` is low, `grant_o` is zero and `vec_valid_o` is low.
- R2: A one-cycle pulse on `svc_req_i[k]` (with `svc_clr_i[k]` low) drives `irq_n_o` low from the next cycle. The line stays low, with no further request, until node k is cleared.
- R3: `irq_n_o` returns high only once no node is pending. When `svc_req_i[k]` and `svc_clr_i[k]` are both high in one cycle, the clear wins and the node does not become pending.
- R4: `ack_o` is a single-cycle strobe. It rises exactly PREP_CYC+1 clock edges after the first edge at which `irq_n_o` is low, with the stub idle.
- R5: During the acknowledge cycle, the pending node with the lowest index claims it. `grant_o` is one-hot at that index, and `bus_o` carries bits [k*VEC_W +: VEC_W] of `node_vec_i`.
- R6: A node that was not pending passes the acknowledge on. `chain_out_o` is high only in an acknowledge cycle that no node claims.
- R7: In the cycle after the acknowledge, `vec_valid_o` pulses high for one cycle and `vec_o` holds the bus value of the acknowledge cycle.
- R8: An unclaimed acknowledge sets `spurious_o`, and `vec_o` then reads all-ones. A claimed acknowledge leaves `spurious_o` low.
- R9: The claim decision uses the pending state at the start of the acknowledge cycle. A request or clear that arrives during that cycle does not change which node is granted.
- R10: With several nodes pending, each acknowledge round whose granted node is cleared in that round serves the next pending node. Nodes are served in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| svc_req_i | input | NODES | Per-node service request, sets the pending flag |
| svc_clr_i | input | NODES | Per-node service clear, removes the pending flag |
| node_vec_i | input | NODES*VEC_W | Identification vector of each node, node k at [k*VEC_W +: VEC_W] |
| irq_n_o | output | 1 | Shared active-low level request line |
| ack_o | output | 1 | Acknowledge strobe into node 0 |
| grant_o | output | NODES | Node that claimed the acknowledge (one-hot) |
| chain_out_o | output | 1 | Acknowledge leaving the last node unclaimed |
| bus_o | output | VEC_W | Shared vector bus, all-ones when undriven |
| vec_o | output | VEC_W | Vector latched by the processor stub |
| vec_valid_o | output | 1 | One-cycle pulse when `vec_o` is updated |
| spurious_o | output | 1 | Last capture found no claiming node |

## Verification
The acknowledge of a node and the clear of that same node can land in the same cycle. A fresh request from a higher-priority node can land there too. The bench does this on purpose: it raises the clear of the granted node, and in one test a new request on node 0, in the very cycle it sees the strobe. It then judges that the grant, bus and latched vector still name the node pending when the strobe began. It also judges that the next round serves the newcomer. A second test clears the only requester during the preparation delay. The strobe then finds no pending node, and the bench expects an all-ones spurious capture.

// File: rtl/daisy_irq_chain.sv
module daisy_irq_chain #(
  parameter int NODES    = 4,
  parameter int VEC_W    = 8,
  parameter int PREP_CYC = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         svc_req_i,
  input  logic [NODES-1:0]         svc_clr_i,
  input  logic [NODES*VEC_W-1:0]   node_vec_i,
  output logic                     irq_n_o,
  output logic                     ack_o,
  output logic [NODES-1:0]         grant_o,
  output logic                     chain_out_o,
  output logic [VEC_W-1:0]         bus_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     vec_valid_o,
  output logic                     spurious_o
);

  localparam int CW = $clog2(PREP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ACK} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [NODES-1:0] pending;
  logic [NODES-1:0] snap;
  logic [NODES:0]   ack_pass;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else        pending <= (pending | svc_req_i) & ~svc_clr_i;

  assign irq_n_o = ~|pending;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      snap  <= '0;
    end else begin
      case (state)
        S_IDLE: if (!irq_n_o) begin
          state <= S_PREP;
          cnt   <= '0;
        end
        S_PREP: if (cnt == CW'(PREP_CYC - 1)) begin
          state <= S_ACK;
          snap  <= pending;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end

  assign ack_o       = (state == S_ACK);
  assign ack_pass[0] = ack_o;

  for (genvar i = 0; i < NODES; i++) begin : g_node
    assign grant_o[i]    = ack_pass[i] & snap[i];
    assign ack_pass[i+1] = ack_pass[i] & ~snap[i];
  end

  assign chain_out_o = ack_pass[NODES];

  always_comb begin
    bus_o = '1;
    for (int i = NODES - 1; i >= 0; i--)
      if (grant_o[i]) bus_o = node_vec_i[i*VEC_W +: VEC_W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      spurious_o  <= 1'b0;
    end else begin
      vec_valid_o <= ack_o;
      if (ack_o) begin
        vec_o      <= bus_o;
        spurious_o <= chain_out_o;
      end
    end

  // R2
  req_sets_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(svc_req_i & ~svc_clr_i)) |=> !irq_n_o);

  // R3
  line_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o && !(|(svc_req_i & ~svc_clr_i))) |=> irq_n_o);

  // R4
  ack_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6
  grant_stops_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> (ack_o && !chain_out_o));

  // R7
  capture_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_o));

  // R8
  spurious_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> (vec_o == '1));

endmodule

// File: tb/test_daisy_irq_chain.sv
module test_daisy_irq_chain;
  localparam int NODES = 4;
  localparam int VEC_W = 8;
  localparam int PREP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NODES-1:0] req = '0, clr = '0;
  logic [NODES*VEC_W-1:0] vecs;
  logic irq_n, ack, chain_out, vvld, spur;
  logic [NODES-1:0] grant;
  logic [VEC_W-1:0] bus, vout;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NODES; i++) begin : g_vec
    assign vecs[i*VEC_W +: VEC_W] = VEC_W'(8'hA0 + i);
  end

  daisy_irq_chain #(.NODES(NODES), .VEC_W(VEC_W), .PREP_CYC(PREP)) i_daisy_irq_chain (
    .clk(clk), .rst_n(rst_n), .svc_req_i(req), .svc_clr_i(clr), .node_vec_i(vecs),
    .irq_n_o(irq_n), .ack_o(ack), .grant_o(grant), .chain_out_o(chain_out),
    .bus_o(bus), .vec_o(vout), .vec_valid_o(vvld), .spurious_o(spur));

  localparam logic [NODES-1:0] MASKS [6] = '{4'b0001, 4'b1000, 4'b0110, 4'b1111, 4'b1010, 4'b0100};

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] vec_of(input int k);
    return VEC_W'(8'hA0 + k);
  endfunction

  task automatic wait_ack(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (ack) begin seen = 1'b1; break; end
    end
    if (!seen) check("R4 ack timeout", 0, 1);
  endtask

  task automatic serve(input int exp_node);
    bit seen;
    wait_ack(seen);
    if (!seen) return;
    if (exp_node < 0) begin
      check("R6 spurious grant", 32'(grant), 0);
      check("R6 chain_out", 32'(chain_out), 1);
      check("R8 bus", 32'(bus), 32'(8'hFF));
    end else begin
      check("R5 grant", 32'(grant), 32'(1 << exp_node));
      check("R5 bus", 32'(bus), 32'(vec_of(exp_node)));
      check("R6 chain_out", 32'(chain_out), 0);
    end
    clr = grant;
    @(negedge clk);
    clr = '0;
    check("R7 valid", 32'(vvld), 1);
    if (exp_node < 0) begin
      check("R8 vec", 32'(vout), 32'(8'hFF));
      check("R8 spurious", 32'(spur), 1);
    end else begin
      check("R7 vec", 32'(vout), 32'(vec_of(exp_node)));
      check("R8 spurious", 32'(spur), 0);
    end
    @(negedge clk);
    check("R7 valid pulse", 32'(vvld), 0);
  endtask

  initial begin
    #200000;
    check("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    // R1
    check("R1 irq_n", 32'(irq_n), 1);
    check("R1 ack", 32'(ack), 0);
    check("R1 grant", 32'(grant), 0);
    check("R1 valid", 32'(vvld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (MASKS[t]) begin
      req = MASKS[t];
      @(negedge clk);
      req = '0;
      check("R2 line low", 32'(irq_n), 0);
      for (int k = 0; k < NODES; k++)
        if (MASKS[t][k]) serve(k);   // R10 ascending order
      check("R3 line high", 32'(irq_n), 1);
    end

    // R4 timing
    req = 4'b0100;
    n = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      req = '0;
      n++;
      if (n == 3) check("R2 level hold", 32'(irq_n), 0);
      if (ack) break;
    end
    check("R4 latency", 32'(n), 32'(PREP + 2));
    clr = grant;
    @(negedge clk);
    clr = '0;
    check("R3 cleared", 32'(irq_n), 1);
    @(negedge clk);

    // R3 clear wins
    req = 4'b0010; clr = 4'b0010;
    @(negedge clk);
    req = '0; clr = '0;
    check("R3 clear wins", 32'(irq_n), 1);
    repeat (PREP + 3) @(negedge clk);
    check("R3 no ack", 32'(ack), 0);

    // R3 line stays low while any node pends
    req = 4'b1001;
    @(negedge clk);
    req = '0;
    clr = 4'b0001;
    @(negedge clk);
    clr = '0;
    check("R3 partial clear", 32'(irq_n), 0);
    serve(3);
    check("R3 line high", 32'(irq_n), 1);

    // R8 spurious: requester withdrawn during prep
    req = 4'b0100;
    @(negedge clk);
    req = '0;
    @(negedge clk);
    clr = 4'b0100;
    @(negedge clk);
    clr = '0;
    check("R8 line high", 32'(irq_n), 1);
    serve(-1);
    repeat (PREP + 3) @(negedge clk);
    check("R8 no repeat ack", 32'(ack), 0);

    // R9 request arriving in the ack cycle
    req = 4'b1000;
    @(negedge clk);
    req = '0;
    wait_ack(seen);
    req = 4'b0001;
    clr = 4'b1000;
    check("R9 grant kept", 32'(grant), 32'(4'b1000));
    @(negedge clk);
    req = '0; clr = '0;
    check("R9 vec kept", 32'(vout), 32'(vec_of(3)));
    serve(0);
    check("R9 line high", 32'(irq_n), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule